// File: doc/BRIEF.md
# CAS Signaling Nibble Packer

This block gathers channel-associated signaling for a circuit-emulation transmit path. When the buffer logic reports that a buffer marked end-of-super-frame has closed, the block walks a circular routing table for the selected trunk. Each 8-bit routing entry names one signaling nibble: an offset into the trunk's CAS block and a choice of the low or high half of the byte at that offset. The block reads that byte from the CAS block memory, picks the nibble, and packs the nibbles two to a byte. The packed bytes go out on a valid/ready stream, which is placed after the super frame's payload. This happens once per super frame.

Both memories are synchronous and return data one cycle after a read strobe. The trunk select and the framing mode are sampled when a walk starts. On the output stream a byte is transferred on any rising edge where `sig_valid_o` and `sig_ready_i` are both high. While `sig_ready_i` is low the block holds `sig_valid_o`, `sig_data_o` and `sig_last_o` steady and stops the table walk, so back-pressure never loses a nibble.

Top module: `cas_nibble_packer`

## Requirements
- R1: On `eosf_i` while the block is idle, a walk starts at entry index 0. Table reads use address {trunk, index}, and the index rises by one per entry. Only one table read is outstanding at a time.
- R2: Entry bit 0 is the most significant bit of the byte (vector bit 7) and is the wrap flag. The walk ends after an entry with this flag set, or after index 2**TBL_AW-1, whichever comes first.
- R3: Entry bit 1 (vector bit 6) is reserved. It has no effect on any output.
- R4: Entry bit 2 (vector bit 5) chooses the nibble. A value of 0 takes CAS byte bits [3:0], and a value of 1 takes bits [7:4].
- R5: Entry bits 3 to 7 (vector bits [4:0]) are the byte offset into the trunk's CAS block. The CAS read address is {trunk, offset}.
- R6: When `e1_mode_i` is 0, any offset above 23 is illegal. For an illegal offset the block issues no CAS read, outputs a zero nibble, and sets `offset_err_o`, which stays set until reset. When `e1_mode_i` is 1, every offset from 0 to 31 is legal.
- R7: The first nibble of each pair goes in bits [7:4] of the output byte and the second in bits [3:0]. If the walk has an odd number of entries, the last byte has zero in bits [3:0]. `sig_last_o` is high only with the final byte of a walk.
- R8: While `sig_valid_o` is high and `sig_ready_i` is low, the output byte and the last flag stay unchanged on the next cycle.
- R9: An `eosf_i` that arrives while `busy_o` is high adds one to `overrun_cnt_o`, which saturates. It does not start a walk and produces no output bytes.
- R10: After reset, `sig_valid_o`, `busy_o`, `offset_err_o`, both read strobes and `overrun_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eosf_i | input | 1 | End-of-super-frame strobe from the buffer logic |
| trunk_i | input | TRK_W | Trunk to walk, sampled at start |
| e1_mode_i | input | 1 | 1 = E1 offset limit 31, 0 = T1 ESF limit 23; sampled at start |
| tbl_rd_o | output | 1 | Routing-table read strobe |
| tbl_addr_o | output | TRK_W+TBL_AW | Routing-table read address |
| tbl_data_i | input | 8 | Routing-table entry, valid one cycle after the strobe |
| cas_rd_o | output | 1 | CAS block read strobe |
| cas_addr_o | output | TRK_W+5 | CAS block read address |
| cas_data_i | input | 8 | CAS byte, valid one cycle after the strobe |
| sig_valid_o | output | 1 | Packed signaling byte valid |
| sig_data_o | output | 8 | Packed signaling byte |
| sig_last_o | output | 1 | Final byte of this super frame's signaling |
| sig_ready_i | input | 1 | Downstream accepts the byte |
| busy_o | output | 1 | A walk is running or a byte is still pending |
| offset_err_o | output | 1 | Sticky illegal-offset flag |
| overrun_cnt_o | output | OVR_W | Saturating count of strobes that arrived while busy |

## Verification
The bench builds the block with four trunks and TBL_AW=3, which gives each trunk an eight-entry table. With that depth, a table that has no wrap flag reaches the index cap in a short run. Random tables often set the wrap flag early, so walks of odd and even length both occur, including one-entry walks. All four trunk regions are used, and the mode changes between walks, so both offset limits and the sticky error path are exercised alongside randomly stalled output.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int OFF_W = 5;

  typedef struct packed {
    logic             wrap;
    logic             rsvd;
    logic             hi_half;
    logic [OFF_W-1:0] offset;
  } route_ent_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TBL_RD,
    ST_TBL_WAIT,
    ST_CAS_WAIT,
    ST_NIB
  } walk_st_e;
endpackage

// File: rtl/cas_entry_decode.sv
module cas_entry_decode
  import cas_pkg::*;
#(
  parameter int ESF_MAX_OFF = 23
) (
  input  logic [7:0]       raw_i,
  input  logic             e1_mode_i,
  output logic             wrap_o,
  output logic             hi_half_o,
  output logic [OFF_W-1:0] offset_o,
  output logic             off_bad_o
);
  localparam int E1_MAX_OFF = (1 << OFF_W) - 1;

  route_ent_t ent;
  assign ent       = route_ent_t'(raw_i);
  assign wrap_o    = ent.wrap;
  assign hi_half_o = ent.hi_half;
  assign offset_o  = ent.offset;
  // offset limit depends on framing; reserved bit deliberately unused
  always_comb begin
    if (e1_mode_i) off_bad_o = (int'(ent.offset) > E1_MAX_OFF);
    else           off_bad_o = (int'(ent.offset) > ESF_MAX_OFF);
  end
endmodule

// File: rtl/cas_walk_ctrl.sv
module cas_walk_ctrl
  import cas_pkg::*;
#(
  parameter int TRK_W       = 2,
  parameter int TBL_AW      = 5,
  parameter int OVR_W       = 8,
  parameter int ESF_MAX_OFF = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    eosf_i,
  input  logic [TRK_W-1:0]        trunk_i,
  input  logic                    e1_mode_i,
  input  logic                    drain_busy_i,
  output logic                    tbl_rd_o,
  output logic [TRK_W+TBL_AW-1:0] tbl_addr_o,
  input  logic [7:0]              tbl_data_i,
  output logic                    cas_rd_o,
  output logic [TRK_W+OFF_W-1:0]  cas_addr_o,
  input  logic [7:0]              cas_data_i,
  output logic                    nib_vld_o,
  output logic [3:0]              nib_o,
  output logic                    nib_last_o,
  input  logic                    nib_rdy_i,
  output logic                    walking_o,
  output logic                    offset_err_o,
  output logic [OVR_W-1:0]        overrun_cnt_o
);
  localparam logic [TBL_AW-1:0] IDX_MAX = {TBL_AW{1'b1}};
  localparam logic [OVR_W-1:0]  OVR_SAT = {OVR_W{1'b1}};

  walk_st_e          st_q;
  logic [TRK_W-1:0]  trunk_q;
  logic              e1_q;
  logic [TBL_AW-1:0] idx_q;
  logic              half_q;
  logic              last_q;
  logic [3:0]        nib_q;
  logic              err_q;
  logic [OVR_W-1:0]  ovr_q;

  logic             d_wrap, d_hi, d_bad;
  logic [OFF_W-1:0] d_off;

  cas_entry_decode #(.ESF_MAX_OFF(ESF_MAX_OFF)) u_dec (
    .raw_i    (tbl_data_i),
    .e1_mode_i(e1_q),
    .wrap_o   (d_wrap),
    .hi_half_o(d_hi),
    .offset_o (d_off),
    .off_bad_o(d_bad)
  );

  logic start, busy_any;
  assign busy_any = (st_q != ST_IDLE) || drain_busy_i;
  assign start    = eosf_i && !busy_any;

  assign tbl_rd_o   = (st_q == ST_TBL_RD);
  assign tbl_addr_o = {trunk_q, idx_q};
  assign cas_rd_o   = (st_q == ST_TBL_WAIT) && !d_bad;
  assign cas_addr_o = {trunk_q, d_off};
  assign nib_vld_o  = (st_q == ST_NIB);
  assign nib_o      = nib_q;
  assign nib_last_o = last_q;
  assign walking_o  = (st_q != ST_IDLE);
  assign offset_err_o  = err_q;
  assign overrun_cnt_o = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      trunk_q <= '0;
      e1_q    <= 1'b0;
      idx_q   <= '0;
      half_q  <= 1'b0;
      last_q  <= 1'b0;
      nib_q   <= '0;
      err_q   <= 1'b0;
      ovr_q   <= '0;
    end else begin
      if (eosf_i && busy_any && ovr_q != OVR_SAT) ovr_q <= ovr_q + 1'b1;
      unique case (st_q)
        ST_IDLE: if (start) begin
          trunk_q <= trunk_i;
          e1_q    <= e1_mode_i;
          idx_q   <= '0;
          st_q    <= ST_TBL_RD;
        end
        ST_TBL_RD: st_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: begin
          last_q <= d_wrap || (idx_q == IDX_MAX);
          half_q <= d_hi;
          if (d_bad) begin
            nib_q <= 4'h0;
            err_q <= 1'b1;
            st_q  <= ST_NIB;
          end else begin
            st_q  <= ST_CAS_WAIT;
          end
        end
        ST_CAS_WAIT: begin
          nib_q <= half_q ? cas_data_i[7:4] : cas_data_i[3:0];
          st_q  <= ST_NIB;
        end
        ST_NIB: if (nib_rdy_i) begin
          if (last_q) st_q <= ST_IDLE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_TBL_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cas_byte_pack.sv
module cas_byte_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nib_vld_i,
  input  logic [3:0] nib_i,
  input  logic       nib_last_i,
  output logic       nib_rdy_o,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  output logic       out_last_o,
  input  logic       out_ready_i
);
  logic       have_hi_q;
  logic [3:0] hi_q;
  logic       ovld_q;
  logic [7:0] odata_q;
  logic       olast_q;

  assign nib_rdy_o   = !ovld_q || out_ready_i;
  assign out_valid_o = ovld_q;
  assign out_data_o  = odata_q;
  assign out_last_o  = olast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_hi_q <= 1'b0;
      hi_q      <= '0;
      ovld_q    <= 1'b0;
      odata_q   <= '0;
      olast_q   <= 1'b0;
    end else begin
      if (ovld_q && out_ready_i) begin
        ovld_q  <= 1'b0;
        olast_q <= 1'b0;
      end
      if (nib_vld_i && nib_rdy_o) begin
        if (have_hi_q) begin
          ovld_q    <= 1'b1;
          odata_q   <= {hi_q, nib_i};
          olast_q   <= nib_last_i;
          have_hi_q <= 1'b0;
        end else if (nib_last_i) begin
          ovld_q  <= 1'b1;
          odata_q <= {nib_i, 4'h0};
          olast_q <= 1'b1;
        end else begin
          hi_q      <= nib_i;
          have_hi_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cas_nibble_packer.sv
module cas_nibble_packer #(
  parameter int NUM_TRUNKS  = 4,
  parameter int TBL_AW      = 5,
  parameter int OVR_W       = 8,
  parameter int ESF_MAX_OFF = 23,
  localparam int TRK_W      = (NUM_TRUNKS > 1) ? $clog2(NUM_TRUNKS) : 1,
  localparam int CAS_AW     = TRK_W + cas_pkg::OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    eosf_i,
  input  logic [TRK_W-1:0]        trunk_i,
  input  logic                    e1_mode_i,
  output logic                    tbl_rd_o,
  output logic [TRK_W+TBL_AW-1:0] tbl_addr_o,
  input  logic [7:0]              tbl_data_i,
  output logic                    cas_rd_o,
  output logic [CAS_AW-1:0]       cas_addr_o,
  input  logic [7:0]              cas_data_i,
  output logic                    sig_valid_o,
  output logic [7:0]              sig_data_o,
  output logic                    sig_last_o,
  input  logic                    sig_ready_i,
  output logic                    busy_o,
  output logic                    offset_err_o,
  output logic [OVR_W-1:0]        overrun_cnt_o
);
  logic       nib_vld, nib_last, nib_rdy, walking;
  logic [3:0] nib;

  cas_walk_ctrl #(
    .TRK_W(TRK_W), .TBL_AW(TBL_AW), .OVR_W(OVR_W), .ESF_MAX_OFF(ESF_MAX_OFF)
  ) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .eosf_i       (eosf_i),
    .trunk_i      (trunk_i),
    .e1_mode_i    (e1_mode_i),
    .drain_busy_i (sig_valid_o),
    .tbl_rd_o     (tbl_rd_o),
    .tbl_addr_o   (tbl_addr_o),
    .tbl_data_i   (tbl_data_i),
    .cas_rd_o     (cas_rd_o),
    .cas_addr_o   (cas_addr_o),
    .cas_data_i   (cas_data_i),
    .nib_vld_o    (nib_vld),
    .nib_o        (nib),
    .nib_last_o   (nib_last),
    .nib_rdy_i    (nib_rdy),
    .walking_o    (walking),
    .offset_err_o (offset_err_o),
    .overrun_cnt_o(overrun_cnt_o)
  );

  cas_byte_pack u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .nib_vld_i  (nib_vld),
    .nib_i      (nib),
    .nib_last_i (nib_last),
    .nib_rdy_o  (nib_rdy),
    .out_valid_o(sig_valid_o),
    .out_data_o (sig_data_o),
    .out_last_o (sig_last_o),
    .out_ready_i(sig_ready_i)
  );

  assign busy_o = walking || sig_valid_o;
endmodule

// File: rtl/cas_nibble_packer_chk.sv
module cas_nibble_packer_chk #(
  parameter int CAS_AW      = 7,
  parameter int OVR_W       = 8,
  parameter int ESF_MAX_OFF = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              e1_mode_i,
  input logic              tbl_rd_o,
  input logic              cas_rd_o,
  input logic [CAS_AW-1:0] cas_addr_o,
  input logic              sig_valid_o,
  input logic [7:0]        sig_data_o,
  input logic              sig_last_o,
  input logic              sig_ready_i,
  input logic              offset_err_o,
  input logic [OVR_W-1:0]  overrun_cnt_o
);
  p_tbl_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_o |=> !tbl_rd_o);

  p_esf_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_rd_o && !e1_mode_i) |-> (int'(cas_addr_o[4:0]) <= ESF_MAX_OFF));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    offset_err_o |=> offset_err_o);

  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sig_last_o |-> sig_valid_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_valid_o && !sig_ready_i) |=>
      (sig_valid_o && $stable(sig_data_o) && $stable(sig_last_o)));

  p_ovr_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_cnt_o >= $past(overrun_cnt_o));
endmodule

bind cas_nibble_packer cas_nibble_packer_chk #(
  .CAS_AW(CAS_AW), .OVR_W(OVR_W), .ESF_MAX_OFF(ESF_MAX_OFF)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .e1_mode_i    (e1_mode_i),
  .tbl_rd_o     (tbl_rd_o),
  .cas_rd_o     (cas_rd_o),
  .cas_addr_o   (cas_addr_o),
  .sig_valid_o  (sig_valid_o),
  .sig_data_o   (sig_data_o),
  .sig_last_o   (sig_last_o),
  .sig_ready_i  (sig_ready_i),
  .offset_err_o (offset_err_o),
  .overrun_cnt_o(overrun_cnt_o)
);

// File: tb/cas_nibble_packer_tb_top.sv
module cas_nibble_packer_tb_top;
  localparam int NT     = 4;
  localparam int TAW    = 3;
  localparam int TRK_W  = 2;
  localparam int CAS_AW = TRK_W + 5;
  localparam int TDEP   = 1 << TAW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                  eosf_i = 1'b0;
  logic [TRK_W-1:0]      trunk_i = '0;
  logic                  e1_mode_i = 1'b0;
  logic                  tbl_rd_o, cas_rd_o;
  logic [TRK_W+TAW-1:0]  tbl_addr_o;
  logic [CAS_AW-1:0]     cas_addr_o;
  logic [7:0]            tbl_data_i = '0, cas_data_i = '0;
  logic                  sig_valid_o, sig_last_o, busy_o, offset_err_o;
  logic                  sig_ready_i = 1'b0;
  logic [7:0]            sig_data_o;
  logic [7:0]            overrun_cnt_o;

  cas_nibble_packer #(.NUM_TRUNKS(NT), .TBL_AW(TAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .eosf_i(eosf_i), .trunk_i(trunk_i),
    .e1_mode_i(e1_mode_i), .tbl_rd_o(tbl_rd_o), .tbl_addr_o(tbl_addr_o),
    .tbl_data_i(tbl_data_i), .cas_rd_o(cas_rd_o), .cas_addr_o(cas_addr_o),
    .cas_data_i(cas_data_i), .sig_valid_o(sig_valid_o), .sig_data_o(sig_data_o),
    .sig_last_o(sig_last_o), .sig_ready_i(sig_ready_i), .busy_o(busy_o),
    .offset_err_o(offset_err_o), .overrun_cnt_o(overrun_cnt_o)
  );

  logic [7:0] tbl_mem [0:NT*TDEP-1];
  logic [7:0] cas_mem [0:(1<<CAS_AW)-1];

  always @(posedge clk) begin
    if (tbl_rd_o) tbl_data_i <= tbl_mem[tbl_addr_o];
    if (cas_rd_o) cas_data_i <= cas_mem[cas_addr_o];
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected-value model
  int exp_b [0:63];
  int exp_n;
  bit exp_err = 0;
  int exp_ovr = 0;

  task automatic model(input int trk, input bit e1);
    int nibs [0:63];
    int nn = 0;
    for (int i = 0; i < TDEP; i++) begin
      logic [7:0] e;
      int off, nb;
      e = tbl_mem[trk*TDEP + i];
      off = int'(e[4:0]);
      if (!e1 && off > 23) begin
        nb = 0; exp_err = 1;
      end else begin
        logic [7:0] c;
        c = cas_mem[trk*32 + off];
        nb = e[5] ? int'(c[7:4]) : int'(c[3:0]);
      end
      nibs[nn] = nb; nn++;
      if (e[7]) break;
    end
    exp_n = (nn + 1) / 2;
    for (int k = 0; k < exp_n; k++) begin
      int lo;
      lo = (2*k+1 < nn) ? nibs[2*k+1] : 0;
      exp_b[k] = nibs[2*k] * 16 + lo;
    end
  endtask

  // read-address monitors
  int cur_trunk = 0;
  bit cur_e1 = 0;
  int mon_idx = 0;
  always @(negedge clk) begin
    if (rst_n && tbl_rd_o) begin
      chk(tbl_addr_o == (TRK_W+TAW)'(cur_trunk*TDEP + mon_idx), "R1",
          "table address", int'(tbl_addr_o), cur_trunk*TDEP + mon_idx);
      mon_idx++;
    end
    if (rst_n && cas_rd_o) begin
      chk(int'(cas_addr_o[CAS_AW-1:5]) == cur_trunk, "R5", "cas trunk",
          int'(cas_addr_o[CAS_AW-1:5]), cur_trunk);
      if (!cur_e1)
        chk(int'(cas_addr_o[4:0]) <= 23, "R6", "esf offset read",
            int'(cas_addr_o[4:0]), 23);
    end
  end

  task automatic fill_random(input int trk);
    for (int i = 0; i < TDEP; i++) begin
      logic [7:0] e;
      e = 8'($urandom);
      e[7] = ($urandom % 5) == 0;
      tbl_mem[trk*TDEP + i] = e;
    end
  endtask

  task automatic run_walk(input int trk, input bit e1, input bit inj, input string tag);
    int got = 0, it = 0;
    bit done = 0, holdpend = 0, r;
    logic [7:0] held;
    logic heldl;
    cur_trunk = trk; cur_e1 = e1; mon_idx = 0;
    model(trk, e1);
    @(negedge clk);
    trunk_i = TRK_W'(trk); e1_mode_i = e1; eosf_i = 1'b1;
    @(negedge clk);
    eosf_i = 1'b0;
    while (!done && it < 2000) begin
      @(negedge clk);
      it++;
      if (inj && it == 2) begin eosf_i = 1'b1; exp_ovr++; end
      else eosf_i = 1'b0;
      if (holdpend) begin
        chk(sig_valid_o && sig_data_o == held && sig_last_o == heldl, "R8",
            "held byte", int'(sig_data_o), int'(held));
        holdpend = 0;
      end
      r = ($urandom % 3) != 0;
      sig_ready_i = r;
      if (sig_valid_o) begin
        if (r) begin
          if (got < 64)
            chk(int'(sig_data_o) == exp_b[got], tag, "packed byte",
                int'(sig_data_o), exp_b[got]);
          if (sig_last_o) begin
            chk(got == exp_n - 1, "R7", "last flag position", got, exp_n - 1);
            done = 1;
          end
          got++;
        end else begin
          held = sig_data_o; heldl = sig_last_o; holdpend = 1;
        end
      end
    end
    if (!done) chk(0, tag, "walk never ended", got, exp_n);
    @(negedge clk);
    eosf_i = 1'b0; sig_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(got == exp_n, "R2", "byte count", got, exp_n);
    chk(!busy_o && !sig_valid_o, "R9", "idle after walk", int'(busy_o), 0);
    chk(int'(overrun_cnt_o) == exp_ovr, "R9", "overrun count",
        int'(overrun_cnt_o), exp_ovr);
    chk(offset_err_o == exp_err, "R6", "sticky error", int'(offset_err_o), int'(exp_err));
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      chk(0, "WDOG", "watchdog expired", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << CAS_AW); i++) cas_mem[i] = 8'($urandom);
    for (int t = 0; t < NT; t++) fill_random(t);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!sig_valid_o && !busy_o && !offset_err_o && !tbl_rd_o && !cas_rd_o &&
        overrun_cnt_o == 0, "R10", "reset state", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // E1: offsets 30/31 legal, odd count padded, both halves (R4, R6, R7)
    tbl_mem[1*TDEP+0] = 8'h3E;
    tbl_mem[1*TDEP+1] = 8'h1F;
    tbl_mem[1*TDEP+2] = 8'hA0;
    run_walk(1, 1'b1, 1'b0, "R4");
    chk(exp_b[1] % 16 == 0, "R7", "odd pad model", exp_b[1] % 16, 0);

    // R3: reserved bit set gives the same bytes
    for (int i = 0; i < 3; i++) tbl_mem[1*TDEP+i] = tbl_mem[1*TDEP+i] | 8'h40;
    run_walk(1, 1'b1, 1'b0, "R3");

    // ESF illegal offset 29 then legal offset 5 (R6)
    tbl_mem[2*TDEP+0] = 8'h1D;
    tbl_mem[2*TDEP+1] = 8'hA5;
    run_walk(2, 1'b0, 1'b0, "R6");
    chk(exp_b[0] / 16 == 0, "R6", "zero nibble model", exp_b[0] / 16, 0);

    // R2: no wrap flag, walk capped at table depth
    for (int i = 0; i < TDEP; i++) tbl_mem[3*TDEP+i] = 8'(($urandom % 24) | (i[0] << 5));
    run_walk(3, 1'b1, 1'b0, "R2");

    // R9: strobe during a walk
    run_walk(0, 1'b1, 1'b1, "R9");

    // random mix (R5, R7)
    for (int n = 0; n < 40; n++) begin
      int t;
      t = int'($urandom % NT);
      fill_random(t);
      run_walk(t, 1'(($urandom % 2)), 1'(($urandom % 2)), "R5");
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule